// File: doc/BRIEF.md
# Hybrid Cellular Automaton Test Pattern Generator

This block is a row of single-bit cells that produces a fresh pseudo-random word on every enabled clock. The word drives the inputs of a circuit under self-test. Each cell computes its next value from itself and the cells on either side of it. A parameter mask gives each cell one of two linear local rules. Rule 90 takes the XOR of the two neighbours. Rule 150 takes the XOR of the two neighbours and the cell itself.

A second parameter sets what lies beyond the two ends of the row. In the null setting, the value there is a constant zero. In the cyclic setting, the first and last cells act as each other's neighbours. A seed can be written at any time with a load strobe, and the load takes priority over stepping. A flag reports when the seed most recently loaded was all zeros, because that state never leaves zero. Picking a rule mask that gives a maximal-length sequence is the integrator's job. The default is the four-cell mask that alternates rule 90 and rule 150, starting with rule 90.

Top module: `hybrid_ca_gen`

## Requirements
- R1: A clock edge with `rst` high sets `cellState` to `RESET_SEED` (default: only cell 0 set, value 1) and clears `zeroSeedErr`.
- R2: Cell i with mask bit `RULE150_MASK[i]` = 0 (rule 90) takes next value left-neighbour XOR right-neighbour. The left neighbour of cell i is cell i-1 and the right neighbour is cell i+1. Bit i of `cellState` is cell i.
- R3: Cell i with mask bit 1 (rule 150) takes next value left XOR own value XOR right.
- R4: With `CYCLIC` = 0, the left neighbour of cell 0 and the right neighbour of the last cell are constant 0.
- R5: With `CYCLIC` = 1, the left neighbour of cell 0 is the last cell and the right neighbour of the last cell is cell 0. For the default mask, state 4'b0001 steps to 4'b1010.
- R6: With `stepEn` and `loadReq` both low, `cellState` keeps its value across the edge.
- R7: With `loadReq` high, the edge writes `seedIn` into `cellState`, whatever the value of `stepEn`.
- R8: For the default 4 cells with null boundary, state 4'b0001 steps in order to 4'b0010, 4'b0111, 4'b1111, 4'b0011 and 4'b0101. It passes through all 15 nonzero states and returns to 4'b0001 after exactly 15 steps.
- R9: The all-zero state stays all zero while stepping.
- R10: After an edge with `loadReq` high, `zeroSeedErr` equals 1 if `seedIn` was zero and 0 otherwise. The flag keeps that value until the next load or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| stepEn | input | 1 | Advance all cells by one generation |
| loadReq | input | 1 | Write `seedIn` into the cells, takes priority over `stepEn` |
| seedIn | input | NUM_CELLS | Seed word, bit i for cell i |
| cellState | output | NUM_CELLS | Current cell values, the pattern for the circuit under test |
| zeroSeedErr | output | 1 | The last loaded seed was all zeros |

## Verification
The cells are the outputs, so a wrong cell value or a wrong neighbour connection shows up on `cellState` at the edge where it happens, and it is only masked if a later XOR cancels it. A wrong rule or boundary at a single cell makes the next word differ from the arithmetic model in at least one bit. The bench therefore loads every possible seed into both a null-boundary copy and a cyclic copy and compares a single step against the model. A slower fault, such as an output that is right but on the wrong cycle, would break the 15-step period and the count of visited states. The walk through the full cycle checks both.

// File: rtl/hca_pkg.sv
package hca_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic loadSeed;
    logic advance;
  } hca_strobe_t;
endpackage

// File: rtl/hca_ctrl.sv
module hca_ctrl #(
  parameter int NUM_CELLS = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    stepEn,
  input  logic                    loadReq,
  input  logic [NUM_CELLS-1:0]    seedIn,
  output hca_pkg::hca_strobe_t    strobes,
  output logic                    zeroSeedErr
);
  // load wins over stepping
  always_comb begin
    strobes.loadSeed = loadReq;
    strobes.advance  = stepEn && !loadReq;
  end

  always_ff @(posedge clk) begin
    if (rst)          zeroSeedErr <= 1'b0;
    else if (loadReq) zeroSeedErr <= (seedIn == '0);
  end
endmodule

// File: rtl/hca_datapath.sv
module hca_datapath #(
  parameter int                   NUM_CELLS    = 4,
  parameter logic [NUM_CELLS-1:0] RULE150_MASK = 4'b1010,
  parameter bit                   CYCLIC       = 1'b0,
  parameter logic [NUM_CELLS-1:0] RESET_SEED   = NUM_CELLS'(1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  hca_pkg::hca_strobe_t    strobes,
  input  logic [NUM_CELLS-1:0]    seedIn,
  output logic [NUM_CELLS-1:0]    cellState
);
  localparam int LAST = NUM_CELLS - 1;

  logic [NUM_CELLS-1:0] leftNb;
  logic [NUM_CELLS-1:0] rightNb;
  logic [NUM_CELLS-1:0] nextState;

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    // left neighbour
    if (i == 0) begin : g_leftEdge
      if (CYCLIC) begin : g_wrap
        assign leftNb[i] = cellState[LAST];
      end else begin : g_null
        assign leftNb[i] = 1'b0;
      end
    end else begin : g_leftIn
      assign leftNb[i] = cellState[i-1];
    end
    // right neighbour
    if (i == LAST) begin : g_rightEdge
      if (CYCLIC) begin : g_wrap
        assign rightNb[i] = cellState[0];
      end else begin : g_null
        assign rightNb[i] = 1'b0;
      end
    end else begin : g_rightIn
      assign rightNb[i] = cellState[i+1];
    end
    // local rule
    if (RULE150_MASK[i]) begin : g_rule150
      assign nextState[i] = leftNb[i] ^ cellState[i] ^ rightNb[i];
    end else begin : g_rule90
      assign nextState[i] = leftNb[i] ^ rightNb[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                   cellState <= RESET_SEED;
    else if (strobes.loadSeed) cellState <= seedIn;
    else if (strobes.advance)  cellState <= nextState;
  end
endmodule

// File: rtl/hybrid_ca_gen.sv
module hybrid_ca_gen #(
  parameter int                   NUM_CELLS    = 4,
  parameter logic [NUM_CELLS-1:0] RULE150_MASK = 4'b1010,
  parameter bit                   CYCLIC       = 1'b0,
  parameter logic [NUM_CELLS-1:0] RESET_SEED   = NUM_CELLS'(1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 stepEn,
  input  logic                 loadReq,
  input  logic [NUM_CELLS-1:0] seedIn,
  output logic [NUM_CELLS-1:0] cellState,
  output logic                 zeroSeedErr
);
  hca_pkg::hca_strobe_t strobes;

  hca_ctrl #(.NUM_CELLS(NUM_CELLS)) u_ctrl (
    .clk(clk), .rst(rst), .stepEn(stepEn), .loadReq(loadReq),
    .seedIn(seedIn), .strobes(strobes), .zeroSeedErr(zeroSeedErr)
  );

  hca_datapath #(
    .NUM_CELLS(NUM_CELLS), .RULE150_MASK(RULE150_MASK),
    .CYCLIC(CYCLIC), .RESET_SEED(RESET_SEED)
  ) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes),
    .seedIn(seedIn), .cellState(cellState)
  );
endmodule

// File: rtl/hybrid_ca_gen_chk.sv
module hybrid_ca_gen_chk #(
  parameter int NUM_CELLS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 stepEn,
  input logic                 loadReq,
  input logic [NUM_CELLS-1:0] seedIn,
  input logic [NUM_CELLS-1:0] cellState,
  input logic                 zeroSeedErr
);
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!stepEn && !loadReq) |=> $stable(cellState)); // R6
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    loadReq |=> cellState == $past(seedIn)); // R7
  AST_ZERO_STUCK: assert property (@(posedge clk) disable iff (rst)
    (cellState == '0 && !loadReq) |=> cellState == '0); // R9
  AST_ERR_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    loadReq |=> zeroSeedErr == ($past(seedIn) == '0)); // R10
  AST_ERR_KEEPS: assert property (@(posedge clk) disable iff (rst)
    !loadReq |=> $stable(zeroSeedErr)); // R10
endmodule

bind hybrid_ca_gen hybrid_ca_gen_chk #(.NUM_CELLS(NUM_CELLS)) u_chk (
  .clk(clk), .rst(rst), .stepEn(stepEn), .loadReq(loadReq),
  .seedIn(seedIn), .cellState(cellState), .zeroSeedErr(zeroSeedErr)
);

// File: tb/test_hybrid_ca_gen.sv
module test_hybrid_ca_gen;
  localparam logic [3:0] MASK = 4'b1010;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stepEn = 1'b0;
  logic loadReq = 1'b0;
  logic [3:0] seedIn = '0;
  logic [3:0] stNull, stCyc;
  logic errNull, errCyc;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hybrid_ca_gen #(.NUM_CELLS(4), .RULE150_MASK(MASK), .CYCLIC(1'b0)) i_hybrid_ca_gen (
    .clk(clk), .rst(rst), .stepEn(stepEn), .loadReq(loadReq), .seedIn(seedIn),
    .cellState(stNull), .zeroSeedErr(errNull));

  hybrid_ca_gen #(.NUM_CELLS(4), .RULE150_MASK(MASK), .CYCLIC(1'b1)) i_hybrid_ca_gen_cyc (
    .clk(clk), .rst(rst), .stepEn(stepEn), .loadReq(loadReq), .seedIn(seedIn),
    .cellState(stCyc), .zeroSeedErr(errCyc));

  function automatic logic [3:0] model(input logic [3:0] s, input bit cyc);
    logic [3:0] n;
    for (int i = 0; i < 4; i++) begin
      logic l, r;
      l = (i == 0) ? (cyc ? s[3] : 1'b0) : s[i-1];
      r = (i == 3) ? (cyc ? s[0] : 1'b0) : s[i+1];
      n[i] = MASK[i] ? (l ^ s[i] ^ r) : (l ^ r);
    end
    return n;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic loadSeed(input logic [3:0] s, input logic en);
    seedIn = s; loadReq = 1'b1; stepEn = en;
    tick();
    loadReq = 1'b0; stepEn = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] refSeq [6];
    logic [15:0] seen;
    int steps;
    refSeq[0] = 4'b0001; refSeq[1] = 4'b0010; refSeq[2] = 4'b0111;
    refSeq[3] = 4'b1111; refSeq[4] = 4'b0011; refSeq[5] = 4'b0101;

    tick(); tick();
    rst = 1'b0;
    chk("R1 reset state", stNull, 4'b0001);
    chk("R1 reset err", errNull, 0);

    // R8 reference walk
    loadSeed(4'b0001, 1'b0);
    stepEn = 1'b1;
    for (int k = 1; k < 6; k++) begin
      tick();
      chk("R8 ref seq", stNull, refSeq[k]);
    end
    stepEn = 1'b0;

    // R8 period and coverage
    loadSeed(4'b0001, 1'b0);
    seen = 16'h0002; steps = 0;
    stepEn = 1'b1;
    do begin
      tick();
      steps++;
      seen[stNull] = 1'b1;
    end while (stNull != 4'b0001 && steps < 40);
    stepEn = 1'b0;
    chk("R8 period", steps, 15);
    chk("R8 all nonzero visited", seen, 16'hFFFE);

    // R5 explicit cyclic case
    loadSeed(4'b0001, 1'b0);
    stepEn = 1'b1; tick(); stepEn = 1'b0;
    chk("R5 cyclic step", stCyc, 4'b1010);

    // R2 R3 R4 R5 exhaustive single step
    for (int s = 0; s < 16; s++) begin
      loadSeed(4'(s), 1'b0);
      stepEn = 1'b1; tick(); stepEn = 1'b0;
      chk("R2 R3 R4 null step", stNull, model(4'(s), 1'b0));
      chk("R2 R3 R5 cyclic step", stCyc, model(4'(s), 1'b1));
    end

    // R6 hold
    loadSeed(4'b1011, 1'b0);
    tick(); tick(); tick();
    chk("R6 hold null", stNull, 4'b1011);
    chk("R6 hold cyc", stCyc, 4'b1011);

    // R7 load beats step
    stepEn = 1'b1; tick();
    loadSeed(4'b0110, 1'b1);
    chk("R7 load over step", stNull, 4'b0110);
    chk("R7 load over step cyc", stCyc, 4'b0110);

    // R9 R10 zero seed
    loadSeed(4'b0000, 1'b0);
    chk("R10 err on zero", errNull, 1);
    stepEn = 1'b1; tick(); tick(); tick(); stepEn = 1'b0;
    chk("R9 zero stays", stNull, 0);
    chk("R9 zero stays cyc", stCyc, 0);
    chk("R10 err held", errNull, 1);
    loadSeed(4'b1000, 1'b0);
    chk("R10 err cleared", errNull, 0);
    stepEn = 1'b1; tick(); stepEn = 1'b0;
    chk("R10 err held low", errNull, 0);

    // R1 reset mid-run
    loadSeed(4'b0000, 1'b0);
    rst = 1'b1; tick(); rst = 1'b0;
    chk("R1 reset mid state", stNull, 4'b0001);
    chk("R1 reset mid err", errCyc, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule